// File: doc/BRIEF.md
# Dual-Slot Receive Frame Buffer

This block takes received Ethernet payload bytes as a push stream, with a start marker on the first byte and an end marker on the last. It stores each frame in one of two receive slots that software owns. Software hands a slot to the hardware by writing its state to "loaded". The block then fills the first loaded slot with the full on-wire image: the payload from byte 8 onward, zero padding up to the minimum payload length, a CRC-32 frame check sequence, and finally the preamble and start-of-frame delimiter in bytes 0 to 7. When the image is complete, the block writes the slot's count register and marks the slot pending.

The buffer memory sits outside the block and is reached through a single byte write port. A level interrupt stays high while either slot is pending. Software acknowledges a frame by rewriting the slot state, and the interrupt follows on the same clock edge. An availability output tells the stream source whether a new frame will be taken. A frame whose first byte arrives while that output is low is discarded in full.

Top module: `rx_dual_slot_buf`

## Requirements
- R1: After reset both slot states read 0 (empty) and both counts read 0. A software write with sw_field=0 sets the chosen slot's state to sw_wdata[1:0], where 0=empty, 1=loaded and 2=pending. A write with sw_field=1 sets the chosen slot's count to sw_wdata.
- R2: A frame goes to slot 0 when slot 0's state is 1, and otherwise to slot 1 when slot 1's state is 1. The other slot's state is left unchanged.
- R3: Bytes 0 to 6 of a stored frame are 0x55 and byte 7 is 0xD5. Payload byte i is stored at offset 8+i.
- R4: A payload shorter than 60 bytes is followed by zero bytes up to a length of 60.
- R5: The 4-byte FCS is stored at offset 8+L, where L is the padded length, least-significant byte first. It is the CRC-32 of the padded payload using reflected polynomial 0xEDB88320, initial value 0xFFFFFFFF and final inversion.
- R6: When a frame is complete, the slot's count becomes L+12 and its state becomes 2 (pending).
- R7: A frame whose payload length plus 12 exceeds SLOT_BYTES is discarded, and the state and count of its slot keep their prior values.
- R8: rx_irq is high exactly when either slot's state is 2. It changes on the same edge as the software write or the completion that causes the change.
- R9: rx_avail is high only when some slot's state is 1 and no frame is in progress. A frame whose start byte arrives while rx_avail is low is dropped entirely, including a frame that arrives while an earlier frame's tail is still being written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Stream byte valid |
| rx_data | input | 8 | Stream byte |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_avail | output | 1 | A new frame will be accepted |
| sw_we | input | 1 | Software register write strobe |
| sw_slot | input | 1 | Slot addressed by the write |
| sw_field | input | 1 | 0 = state, 1 = count |
| sw_wdata | input | CNT_W | Write data |
| slot_state_o | output | 4 | Slot 1 state [3:2], slot 0 state [1:0] |
| slot_count_o | output | 2*CNT_W | Slot 1 count (upper), slot 0 count (lower) |
| buf_we | output | 1 | Buffer byte write enable |
| buf_slot | output | 1 | Slot written |
| buf_addr | output | ADDR_W | Byte offset within the slot |
| buf_data | output | 8 | Byte written |
| rx_irq | output | 1 | Receive interrupt level |

## Verification
The bench builds the block with SLOT_BYTES=96, so the largest accepted payload is 84 bytes. This puts the exact-fit frame, and the one-byte-larger frame that must be discarded, within a few dozen cycles. At the default size the same boundary would need more than two thousand stream bytes per frame. The smaller slot also keeps the captured buffer image small enough to compare byte for byte in every region: preamble, payload, padding and FCS.

// File: rtl/rxsb_pkg.sv
package rxsb_pkg;

  localparam int NSLOT   = 2;
  localparam int MIN_PAY = 60;
  localparam int HDR     = 8;
  localparam int OVERHD  = 12;

  typedef enum logic [1:0] {
    SLOT_EMPTY   = 2'd0,
    SLOT_LOADED  = 2'd1,
    SLOT_PENDING = 2'd2
  } slot_st_e;

  typedef enum logic [2:0] {
    W_IDLE, W_PAY, W_SKIP, W_PAD, W_FCS, W_PRE
  } wr_st_e;

  // one byte of reflected CRC-32, LSB-first
  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int i = 0; i < 8; i++)
      r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  function automatic logic [7:0] fcs_byte(input logic [31:0] c, input logic [1:0] k);
    logic [31:0] f;
    f = ~c;
    return 8'(f >> {k, 3'b000});
  endfunction

  function automatic logic [7:0] preamble_byte(input logic [2:0] k);
    return (k == 3'd7) ? 8'hD5 : 8'h55;
  endfunction

endpackage

// File: rtl/rxsb_slot_regs.sv
module rxsb_slot_regs
  import rxsb_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sw_we,
  input  logic                   sw_slot,
  input  logic                   sw_field,
  input  logic [CNT_W-1:0]       sw_wdata,
  input  logic                   commit,
  input  logic                   commit_slot,
  input  logic [CNT_W-1:0]       commit_count,
  output logic [2*NSLOT-1:0]     slot_state,
  output logic [NSLOT*CNT_W-1:0] slot_count,
  output logic                   any_loaded,
  output logic                   any_pending,
  output logic                   sel_slot
);

  logic [1:0]       st_q  [NSLOT];
  logic [CNT_W-1:0] cnt_q [NSLOT];
  logic [NSLOT-1:0] loaded_v, pending_v;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    wire hit_hw = commit && (commit_slot == 1'(s));
    wire hit_sw = sw_we && (sw_slot == 1'(s));

    // hardware completion takes the whole slot over a same-cycle software write
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q[s]  <= SLOT_EMPTY;
        cnt_q[s] <= '0;
      end else if (hit_hw) begin
        st_q[s]  <= SLOT_PENDING;
        cnt_q[s] <= commit_count;
      end else if (hit_sw) begin
        if (sw_field) cnt_q[s] <= sw_wdata;
        else          st_q[s]  <= sw_wdata[1:0];
      end
    end

    assign loaded_v[s]  = (st_q[s] == SLOT_LOADED);
    assign pending_v[s] = (st_q[s] == SLOT_PENDING);
    assign slot_state[2*s +: 2]         = st_q[s];
    assign slot_count[CNT_W*s +: CNT_W] = cnt_q[s];
  end

  assign any_loaded  = |loaded_v;
  assign any_pending = |pending_v;
  assign sel_slot    = !loaded_v[0];

endmodule

// File: rtl/rxsb_frame_writer.sv
module rxsb_frame_writer
  import rxsb_pkg::*;
#(
  parameter int SLOT_BYTES = 2048,
  parameter int ADDR_W     = $clog2(SLOT_BYTES),
  parameter int CNT_W      = $clog2(SLOT_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic              any_loaded,
  input  logic              sel_slot,
  output logic              idle,
  output logic              buf_we,
  output logic              buf_slot,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [7:0]        buf_data,
  output logic              frame_start,
  output logic              commit,
  output logic              commit_slot,
  output logic [CNT_W-1:0]  commit_count
);

  localparam int LEN_W   = ADDR_W;
  localparam int MAX_PAY = SLOT_BYTES - OVERHD;

  wr_st_e      st_q;
  logic        slot_q;
  logic [LEN_W-1:0] len_q;
  logic [31:0] crc_q;
  logic [2:0]  idx_q;
  logic        ovf_q;

  wire room     = (32'(len_q) < MAX_PAY);
  wire pay_take = (st_q == W_PAY) && rx_valid && room;
  wire [ADDR_W-1:0] pay_addr = ADDR_W'(32'(len_q) + HDR);
  wire [ADDR_W-1:0] fcs_addr = ADDR_W'(32'(len_q) + HDR + 32'(idx_q));

  assign idle         = (st_q == W_IDLE);
  assign frame_start  = idle && rx_valid && rx_sof && any_loaded;
  assign commit       = (st_q == W_PRE) && (idx_q == 3'd7);
  assign commit_slot  = slot_q;
  assign commit_count = CNT_W'(32'(len_q) + OVERHD);

  always_comb begin
    buf_we   = 1'b0;
    buf_slot = slot_q;
    buf_addr = '0;
    buf_data = 8'h00;
    unique case (st_q)
      W_IDLE: if (frame_start) begin
        buf_we   = 1'b1;
        buf_slot = sel_slot;
        buf_addr = ADDR_W'(HDR);
        buf_data = rx_data;
      end
      W_PAY: if (pay_take) begin
        buf_we   = 1'b1;
        buf_addr = pay_addr;
        buf_data = rx_data;
      end
      W_PAD: begin
        buf_we   = 1'b1;
        buf_addr = pay_addr;
      end
      W_FCS: begin
        buf_we   = 1'b1;
        buf_addr = fcs_addr;
        buf_data = fcs_byte(crc_q, idx_q[1:0]);
      end
      W_PRE: begin
        buf_we   = 1'b1;
        buf_addr = ADDR_W'(idx_q);
        buf_data = preamble_byte(idx_q);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= W_IDLE;
      slot_q <= 1'b0;
      len_q  <= '0;
      crc_q  <= '1;
      idx_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      unique case (st_q)
        W_IDLE: if (rx_valid && rx_sof) begin
          if (any_loaded) begin
            slot_q <= sel_slot;
            len_q  <= LEN_W'(1);
            crc_q  <= crc32_step(32'hFFFF_FFFF, rx_data);
            ovf_q  <= 1'b0;
            st_q   <= rx_eof ? W_PAD : W_PAY;
          end else if (!rx_eof) begin
            st_q <= W_SKIP;
          end
        end
        W_PAY: if (rx_valid) begin
          if (room) begin
            len_q <= len_q + 1'b1;
            crc_q <= crc32_step(crc_q, rx_data);
          end else begin
            ovf_q <= 1'b1;
          end
          if (rx_eof) begin
            idx_q <= '0;
            if (ovf_q || !room)                   st_q <= W_IDLE;
            else if (32'(len_q) < MIN_PAY - 1)    st_q <= W_PAD;
            else                                  st_q <= W_FCS;
          end
        end
        W_SKIP: if (rx_valid && rx_eof) st_q <= W_IDLE;
        W_PAD: begin
          len_q <= len_q + 1'b1;
          crc_q <= crc32_step(crc_q, 8'h00);
          if (32'(len_q) == MIN_PAY - 1) begin
            st_q  <= W_FCS;
            idx_q <= '0;
          end
        end
        W_FCS: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == 3'd3) begin
            st_q  <= W_PRE;
            idx_q <= '0;
          end
        end
        W_PRE: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == 3'd7) st_q <= W_IDLE;
        end
        default: st_q <= W_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rx_dual_slot_buf.sv
module rx_dual_slot_buf
  import rxsb_pkg::*;
#(
  parameter  int SLOT_BYTES = 2048,
  localparam int CNT_W      = $clog2(SLOT_BYTES + 1),
  localparam int ADDR_W     = $clog2(SLOT_BYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_valid,
  input  logic [7:0]         rx_data,
  input  logic               rx_sof,
  input  logic               rx_eof,
  output logic               rx_avail,
  input  logic               sw_we,
  input  logic               sw_slot,
  input  logic               sw_field,
  input  logic [CNT_W-1:0]   sw_wdata,
  output logic [3:0]         slot_state_o,
  output logic [2*CNT_W-1:0] slot_count_o,
  output logic               buf_we,
  output logic               buf_slot,
  output logic [ADDR_W-1:0]  buf_addr,
  output logic [7:0]         buf_data,
  output logic               rx_irq
);

  logic             any_loaded, any_pending, sel_slot, wr_idle;
  logic             frame_start, commit, commit_slot;
  logic [CNT_W-1:0] commit_count;

  rxsb_slot_regs #(.CNT_W(CNT_W)) regs_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sw_we        (sw_we),
    .sw_slot      (sw_slot),
    .sw_field     (sw_field),
    .sw_wdata     (sw_wdata),
    .commit       (commit),
    .commit_slot  (commit_slot),
    .commit_count (commit_count),
    .slot_state   (slot_state_o),
    .slot_count   (slot_count_o),
    .any_loaded   (any_loaded),
    .any_pending  (any_pending),
    .sel_slot     (sel_slot)
  );

  rxsb_frame_writer #(
    .SLOT_BYTES (SLOT_BYTES),
    .ADDR_W     (ADDR_W),
    .CNT_W      (CNT_W)
  ) writer_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_valid     (rx_valid),
    .rx_data      (rx_data),
    .rx_sof       (rx_sof),
    .rx_eof       (rx_eof),
    .any_loaded   (any_loaded),
    .sel_slot     (sel_slot),
    .idle         (wr_idle),
    .buf_we       (buf_we),
    .buf_slot     (buf_slot),
    .buf_addr     (buf_addr),
    .buf_data     (buf_data),
    .frame_start  (frame_start),
    .commit       (commit),
    .commit_slot  (commit_slot),
    .commit_count (commit_count)
  );

  assign rx_avail = any_loaded && wr_idle;
  assign rx_irq   = any_pending;

endmodule

// File: rtl/rx_dual_slot_buf_chk.sv
module rx_dual_slot_buf_chk #(
  parameter int CNT_W  = 12,
  parameter int ADDR_W = 11
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sw_we,
  input logic               rx_irq,
  input logic               rx_avail,
  input logic [3:0]         slot_state_o,
  input logic [2*CNT_W-1:0] slot_count_o,
  input logic               buf_we,
  input logic [ADDR_W-1:0]  buf_addr,
  input logic [7:0]         buf_data,
  input logic               frame_start,
  input logic               start_slot,
  input logic               commit,
  input logic               commit_slot
);

  a_r2_start_slot0: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && !start_slot |-> slot_state_o[1:0] == 2'd1);

  a_r2_start_slot1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && start_slot |-> slot_state_o[1:0] != 2'd1 && slot_state_o[3:2] == 2'd1);

  a_r3_preamble_55: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we && buf_addr < ADDR_W'(7) |-> buf_data == 8'h55);

  a_r3_sfd_d5: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we && buf_addr == ADDR_W'(7) |-> buf_data == 8'hD5);

  a_r6_commit_pending0: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !commit_slot |=> slot_state_o[1:0] == 2'd2 && slot_count_o[CNT_W-1:0] >= CNT_W'(72));

  a_r6_commit_pending1: assert property (@(posedge clk) disable iff (!rst_n)
    commit && commit_slot |=> slot_state_o[3:2] == 2'd2 && slot_count_o[2*CNT_W-1:CNT_W] >= CNT_W'(72));

  a_r8_irq_falls_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_irq) |-> $past(sw_we));

  a_r9_avail_needs_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    rx_avail |-> slot_state_o[1:0] == 2'd1 || slot_state_o[3:2] == 2'd1);

endmodule

bind rx_dual_slot_buf rx_dual_slot_buf_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .sw_we        (sw_we),
  .rx_irq       (rx_irq),
  .rx_avail     (rx_avail),
  .slot_state_o (slot_state_o),
  .slot_count_o (slot_count_o),
  .buf_we       (buf_we),
  .buf_addr     (buf_addr),
  .buf_data     (buf_data),
  .frame_start  (frame_start),
  .start_slot   (sel_slot),
  .commit       (commit),
  .commit_slot  (commit_slot)
);

// File: tb/rx_dual_slot_buf_tb_top.sv
`timescale 1ns/1ps
module rx_dual_slot_buf_tb_top;

  localparam int SLOT   = 96;
  localparam int CNT_W  = $clog2(SLOT + 1);
  localparam int ADDR_W = $clog2(SLOT);

  typedef struct packed {
    logic [15:0] len;
    logic [7:0]  seed;
    logic [1:0]  s0;
    logic [1:0]  s1;
    logic        ok;
    logic        slot;
  } vec_t;

  // len, seed, slot0 state, slot1 state, stored, expected slot
  localparam vec_t VECS [8] = '{
    '{16'd1,  8'h11, 2'd1, 2'd0, 1'b1, 1'b0},
    '{16'd59, 8'h22, 2'd0, 2'd1, 1'b1, 1'b1},
    '{16'd60, 8'h33, 2'd1, 2'd1, 1'b1, 1'b0},
    '{16'd61, 8'h44, 2'd2, 2'd1, 1'b1, 1'b1},
    '{16'd84, 8'h55, 2'd1, 2'd0, 1'b1, 1'b0},
    '{16'd85, 8'h66, 2'd1, 2'd0, 1'b0, 1'b0},
    '{16'd20, 8'h77, 2'd0, 2'd0, 1'b0, 1'b0},
    '{16'd30, 8'h88, 2'd3, 2'd1, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic sw_we = 1'b0, sw_slot = 1'b0, sw_field = 1'b0;
  logic [CNT_W-1:0] sw_wdata = '0;
  logic rx_avail, buf_we, buf_slot, rx_irq;
  logic [3:0] slot_state_o;
  logic [2*CNT_W-1:0] slot_count_o;
  logic [ADDR_W-1:0] buf_addr;
  logic [7:0] buf_data;

  always #10 clk = ~clk;

  rx_dual_slot_buf #(.SLOT_BYTES(SLOT)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_avail(rx_avail),
    .sw_we(sw_we), .sw_slot(sw_slot), .sw_field(sw_field), .sw_wdata(sw_wdata),
    .slot_state_o(slot_state_o), .slot_count_o(slot_count_o),
    .buf_we(buf_we), .buf_slot(buf_slot), .buf_addr(buf_addr), .buf_data(buf_data),
    .rx_irq(rx_irq)
  );

  logic [7:0] mem [2][SLOT];
  always @(negedge clk) if (buf_we) mem[buf_slot][buf_addr] = buf_data;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int st(input int s);
    return int'(slot_state_o[2*s +: 2]);
  endfunction
  function automatic int cnt(input int s);
    return int'(slot_count_o[CNT_W*s +: CNT_W]);
  endfunction

  task automatic sw_write(input bit slot, input bit field, input int val);
    @(posedge clk); #2;
    sw_we = 1'b1; sw_slot = slot; sw_field = field; sw_wdata = CNT_W'(val);
    @(posedge clk); #2;
    sw_we = 1'b0;
  endtask

  function automatic logic [7:0] pbyte(input logic [7:0] seed, input int i);
    return 8'(int'(seed) + i * 7);
  endfunction

  task automatic send(input int len, input logic [7:0] seed);
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #2;
      rx_valid = 1'b1; rx_data = pbyte(seed, i);
      rx_sof = (i == 0); rx_eof = (i == len - 1);
    end
    @(posedge clk); #2;
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
  endtask

  task automatic clear_mem();
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < SLOT; a++) mem[s][a] = 8'hEE;
  endtask

  // reference CRC, bit-serial
  function automatic logic [31:0] ref_fcs(input logic [7:0] seed, input int len, input int plen);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < plen; i++) begin
      logic [7:0] d = (i < len) ? pbyte(seed, i) : 8'h00;
      for (int b = 0; b < 8; b++) begin
        logic fb = c[0] ^ d[b];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    return ~c;
  endfunction

  task automatic check_image(input bit s, input int len, input logic [7:0] seed);
    int plen = (len < 60) ? 60 : len;
    int bad;
    logic [31:0] f = ref_fcs(seed, len, plen);
    bad = 0;
    for (int a = 0; a < 8; a++) if (mem[s][a] != ((a == 7) ? 8'hD5 : 8'h55)) bad++;
    check("R3 preamble bytes wrong", bad, 0);
    bad = 0;
    for (int i = 0; i < len; i++) if (mem[s][8+i] != pbyte(seed, i)) bad++;
    check("R3 payload bytes wrong", bad, 0);
    bad = 0;
    for (int i = len; i < plen; i++) if (mem[s][8+i] != 8'h00) bad++;
    check("R4 pad bytes wrong", bad, 0);
    bad = 0;
    for (int k = 0; k < 4; k++) if (mem[s][8+plen+k] != f[8*k +: 8]) bad++;
    check("R5 fcs bytes wrong", bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state0", st(0), 0);
    check("R1 reset state1", st(1), 0);
    check("R1 reset count0", cnt(0), 0);
    check("R1 reset count1", cnt(1), 0);
    check("R8 reset irq", int'(rx_irq), 0);
    check("R9 avail with nothing loaded", int'(rx_avail), 0);

    sw_write(1'b1, 1'b1, 37);
    @(negedge clk);
    check("R1 count write readback", cnt(1), 37);

    foreach (VECS[v]) begin
      vec_t t = VECS[v];
      int plen = (int'(t.len) < 60) ? 60 : int'(t.len);
      sw_write(1'b0, 1'b1, 0);
      sw_write(1'b1, 1'b1, 0);
      sw_write(1'b0, 1'b0, int'(t.s0));
      sw_write(1'b1, 1'b0, int'(t.s1));
      clear_mem();
      @(negedge clk);
      check("R9 avail follows loaded", int'(rx_avail), int'(t.s0 == 2'd1 || t.s1 == 2'd1));
      send(int'(t.len), t.seed);
      repeat (100) @(posedge clk);
      @(negedge clk);
      if (t.ok) begin
        check("R6 state pending", st(int'(t.slot)), 2);
        check("R6 count", cnt(int'(t.slot)), plen + 12);
        check("R2 other slot untouched", st(int'(!t.slot)), int'(t.slot ? t.s0 : t.s1));
        check("R8 irq high while pending", int'(rx_irq), 1);
        check_image(t.slot, int'(t.len), t.seed);
      end else begin
        check("R7/R9 dropped state0", st(0), int'(t.s0));
        check("R7/R9 dropped state1", st(1), int'(t.s1));
        check("R7/R9 dropped count0", cnt(0), 0);
        check("R7/R9 dropped count1", cnt(1), 0);
        if (t.len == 16'd20) check("R9 nothing written", int'(mem[0][8] == 8'hEE && mem[1][8] == 8'hEE), 1);
      end
    end

    // R8: irq falls only when the last pending slot is released
    sw_write(1'b0, 1'b0, 2);
    sw_write(1'b1, 1'b0, 2);
    sw_write(1'b0, 1'b0, 0);
    @(negedge clk);
    check("R8 irq stays with one pending", int'(rx_irq), 1);
    sw_write(1'b1, 1'b0, 0);
    @(negedge clk);
    check("R8 irq drops after release", int'(rx_irq), 0);
    check("R1 state write readback", st(1), 0);

    // R9: a frame arriving during the previous tail is dropped
    sw_write(1'b0, 1'b1, 0);
    sw_write(1'b1, 1'b1, 0);
    sw_write(1'b0, 1'b0, 1);
    sw_write(1'b1, 1'b0, 1);
    send(10, 8'h05);
    @(negedge clk);
    check("R9 avail low during tail", int'(rx_avail), 0);
    send(5, 8'h09);
    repeat (100) @(posedge clk);
    @(negedge clk);
    check("R9 first frame stored", st(0), 2);
    check("R9 first frame count", cnt(0), 72);
    check("R9 second frame dropped", st(1), 1);
    check("R9 second frame count", cnt(1), 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule